// File: doc/BRIEF.md
# Cascaded Low-Power Match Timer

This block is a timer for the low-frequency part of a chip. It has three counters. Two counters of CNT_W bits each, called C0 and C1, can be chained. Every time C0 hits its match value, C1 advances by one. Together they set a long wake-up delay. The third counter, C2, runs freely and serves as a readable timebase. Its event fires when a chosen bit of the count rises. As an option, C2 can advance only on C1 hits.

All counting happens in a single clock domain. It is paced by a low-frequency tick enable, `tick_i`. A match value that software writes does not take effect at once: it is moved into the comparator on a later tick. Enable changes show up in a status register two ticks after they are made. Each counter has a sticky interrupt cause bit. Software clears a cause bit by writing 1 to it. A mask register decides which cause bits drive the interrupt output.

Top module: `lp_cascade_timer`

## Requirements
- R1: After reset, the registers hold the following values:
  - MATCH0 and MATCH1 read all ones.
  - CFG reads 0x023: C0 and C1 in interrupt mode, C0→C1 chaining on, every other bit zero.
  - All counts, CAUSE, MASK, ENABLE and STATUS read 0, and `irq_o` is low.
- R2: On each cycle where `tick_i` is high, an enabled counter advances by one. A disabled counter holds its value.
- R3: STATUS bit i copies ENABLE bit i after two ticks: the first tick after the write still shows the old value, and the second tick shows the new one.
- R4: C0 hits on a tick where its count equals the active match value. If CFG bit 3 (C0 clear) is set, the count then becomes 0. Otherwise it keeps counting up.
- R5: When CFG bit 5 (chaining) is set, a C0 hit is queued, and C1 advances on the next tick. When the bit is clear, C1 advances on every tick.
- R6: C1 hits under one of two rules. With parameter C1_PAST_MATCH=1, it hits when it advances away from its match value. With C1_PAST_MATCH=0, it hits when it advances onto the match value. CFG bit 4 clears C1 to 0 on a hit.
- R7: A write to MATCH0 or MATCH1 is copied into the comparator on the next tick. The compare made on that tick still uses the old value.
- R8: C2 wraps at 2^C2_W. In interrupt mode (CFG bit 2), its cause bit sets when the count bit selected by CFG[7 +: log2(C2_W)] goes from 0 to 1.
- R9: When CFG bit 6 is set, C2 advances only on ticks where C1 hits.
- R10: The cause bits are laid out as bit0=C0, bit1=C1 and bit2=C2. They set on an event in interrupt mode, with CFG bits 0, 1 and 2 giving the mode for each counter. Writing 1 to a CAUSE bit clears it, but a set in the same cycle wins. `irq_o` is the OR of (CAUSE AND MASK).
- R11: The register map is 0 ENABLE[2:0], 1 CFG, 2 MATCH0, 3 MATCH1, 4 MASK[2:0], 5 CAUSE, 6 COUNT0, 7 COUNT1, 8 COUNT2 and 9 STATUS[2:0]. `rdata_o` returns the register at `addr_i` one clock after `addr_i` is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Low-frequency count enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds two copies of the block with C2_W=8. One copy uses C1_PAST_MATCH=1 and the other uses C1_PAST_MATCH=0, so both C1 hit rules are checked on the same tick in the same stimulus. The narrow C2 lets the bench sweep every toggle-bit position up to bit 2 and run through a full C2 wrap in a few hundred ticks. The bench also sweeps small C0 and C1 match pairs with clear-on-hit enabled. For each pair, it checks the exact tick at which the chained delay fires, computed arithmetically from the two match values.

// File: rtl/lp_timer_pkg.sv
package lp_timer_pkg;
  typedef enum logic [3:0] {
    A_ENABLE = 4'd0,
    A_CFG    = 4'd1,
    A_MATCH0 = 4'd2,
    A_MATCH1 = 4'd3,
    A_MASK   = 4'd4,
    A_CAUSE  = 4'd5,
    A_COUNT0 = 4'd6,
    A_COUNT1 = 4'd7,
    A_COUNT2 = 4'd8,
    A_STATUS = 4'd9
  } reg_addr_e;

  localparam int CFG_W      = 12;
  localparam int CFG_MODE0  = 0;
  localparam int CFG_MODE1  = 1;
  localparam int CFG_MODE2  = 2;
  localparam int CFG_CLR0   = 3;
  localparam int CFG_CLR1   = 4;
  localparam int CFG_CASC01 = 5;
  localparam int CFG_CASC12 = 6;
  localparam int CFG_TOG    = 7;
  localparam logic [CFG_W-1:0] CFG_RST = 12'h023;
endpackage

// File: rtl/lp_match_cnt.sv
module lp_match_cnt #(
  parameter int W          = 16,
  parameter bit PAST_MATCH = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic [W-1:0] match_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, nxt;

  always_comb begin
    nxt   = cnt_q + 1'b1;
    // past rule: hit when leaving match; equality rule: hit when landing on it
    hit_o = inc_i && (PAST_MATCH ? (cnt_q == match_i) : (nxt == match_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= (hit_o && clr_i) ? '0 : nxt;
  end

  assign cnt_o = cnt_q;

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
  p_clear_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/lp_free_cnt.sv
module lp_free_cnt #(
  parameter int W     = 32,
  parameter int SEL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     cnt_o,
  output logic             rise_o
);
  logic [W-1:0] cnt_q, nxt;

  assign nxt    = cnt_q + 1'b1;
  assign rise_o = inc_i && !cnt_q[sel_i] && nxt[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;

  p_free_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/lp_irq.sv
module lp_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] cause_o,
  output logic         irq_o
);
  logic [N-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & ~clr_i) | set_i;
  end

  assign cause_o = cause_q;
  assign irq_o   = |(cause_q & mask_i);

  p_set_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i)));
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !set_i[0]) |=> !cause_q[0]);
endmodule

// File: rtl/lp_cascade_timer.sv
module lp_cascade_timer
  import lp_timer_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int C2_W          = 32,
  parameter int DATA_W        = 32,
  parameter bit C1_PAST_MATCH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int TOG_W = (C2_W > 1) ? $clog2(C2_W) : 1;

  reg_addr_e        addr;
  logic [2:0]       en_q, en_s1_q, en_s2_q, mask_q, cause, set_c, clr_c;
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] m_reg_q [2];
  logic [CNT_W-1:0] m_act_q [2];
  logic [CNT_W-1:0] cnt [2];
  logic [1:0]       inc, hit;
  logic             carry_q, inc2, rise2;
  logic [C2_W-1:0]  cnt2;
  logic [DATA_W-1:0] rdata_d;
  logic             unused_wdata;

  assign addr         = reg_addr_e'(addr_i);
  assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= '0;
      cfg_q      <= CFG_RST;
      mask_q     <= '0;
      m_reg_q[0] <= '1;
      m_reg_q[1] <= '1;
    end else if (we_i) begin
      case (addr)
        A_ENABLE: en_q       <= wdata_i[2:0];
        A_CFG:    cfg_q      <= wdata_i[CFG_W-1:0];
        A_MATCH0: m_reg_q[0] <= wdata_i[CNT_W-1:0];
        A_MATCH1: m_reg_q[1] <= wdata_i[CNT_W-1:0];
        A_MASK:   mask_q     <= wdata_i[2:0];
        default:  ;
      endcase
    end
  end

  // low-frequency stage: match transfer, status sync, queued carry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1_q    <= '0;
      en_s2_q    <= '0;
      m_act_q[0] <= '1;
      m_act_q[1] <= '1;
      carry_q    <= 1'b0;
    end else if (tick_i) begin
      en_s1_q    <= en_q;
      en_s2_q    <= en_s1_q;
      m_act_q[0] <= m_reg_q[0];
      m_act_q[1] <= m_reg_q[1];
      carry_q    <= hit[0] && cfg_q[CFG_CASC01];
    end
  end

  assign inc[0] = tick_i && en_q[0];
  assign inc[1] = tick_i && en_q[1] && (cfg_q[CFG_CASC01] ? carry_q : 1'b1);
  assign inc2   = tick_i && en_q[2] && (cfg_q[CFG_CASC12] ? hit[1] : 1'b1);

  for (genvar i = 0; i < 2; i++) begin : g_mcnt
    lp_match_cnt #(
      .W          (CNT_W),
      .PAST_MATCH ((i == 0) ? 1'b1 : C1_PAST_MATCH)
    ) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[i]),
      .clr_i   (cfg_q[CFG_CLR0+i]),
      .match_i (m_act_q[i]),
      .cnt_o   (cnt[i]),
      .hit_o   (hit[i])
    );
  end

  lp_free_cnt #(.W(C2_W), .SEL_W(TOG_W)) u_free (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc2),
    .sel_i  (cfg_q[CFG_TOG +: TOG_W]),
    .cnt_o  (cnt2),
    .rise_o (rise2)
  );

  assign set_c = {cfg_q[CFG_MODE2] && rise2,
                  cfg_q[CFG_MODE1] && hit[1],
                  cfg_q[CFG_MODE0] && hit[0]};
  assign clr_c = (we_i && addr == A_CAUSE) ? wdata_i[2:0] : 3'b000;

  lp_irq #(.N(3)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_c),
    .clr_i   (clr_c),
    .mask_i  (mask_q),
    .cause_o (cause),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    case (addr)
      A_ENABLE: rdata_d[2:0]       = en_q;
      A_CFG:    rdata_d[CFG_W-1:0] = cfg_q;
      A_MATCH0: rdata_d[CNT_W-1:0] = m_reg_q[0];
      A_MATCH1: rdata_d[CNT_W-1:0] = m_reg_q[1];
      A_MASK:   rdata_d[2:0]       = mask_q;
      A_CAUSE:  rdata_d[2:0]       = cause;
      A_COUNT0: rdata_d[CNT_W-1:0] = cnt[0];
      A_COUNT1: rdata_d[CNT_W-1:0] = cnt[1];
      A_COUNT2: rdata_d[C2_W-1:0]  = cnt2;
      A_STATUS: rdata_d[2:0]       = en_s2_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end

  p_carry_queued_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit[0] && cfg_q[CFG_CASC01]) |=> carry_q);
  p_match_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(m_act_q[0]) && $stable(m_act_q[1])));
  p_status_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (en_s2_q == $past(en_s1_q)));
  p_c2_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[CFG_CASC12] && !hit[1]) |=> $stable(cnt2));
endmodule

// File: tb/lp_cascade_timer_bench.sv
module lp_cascade_timer_bench;
  localparam int CLK_P = 10;
  localparam int C2W   = 8;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lp_cascade_timer #(.C2_W(C2W), .C1_PAST_MATCH(1'b1)) u_lp_cascade_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_a), .irq_o(irq_a));
  lp_cascade_timer #(.C2_W(C2W), .C1_PAST_MATCH(1'b0)) u_lp_cascade_timer_eq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_b), .irq_o(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0; we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk); addr = a;
    @(negedge clk); va = rd_a; vb = rd_b;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, vb;
    do_reset();
    // R1 and R11 reset image
    rd(4'd2, va, vb); chk("R1 R11 match0", va, 32'hFFFF);
    rd(4'd3, va, vb); chk("R1 match1", va, 32'hFFFF);
    rd(4'd1, va, vb); chk("R1 cfg", va, 32'h023);
    for (int a = 6; a <= 8; a++) begin
      rd(4'(a), va, vb); chk("R1 count", va, 0);
    end
    rd(4'd5, va, vb); chk("R1 cause", va, 0);
    rd(4'd9, va, vb); chk("R1 status", va, 0);
    chk("R1 irq", {31'b0, irq_a}, 0);

    // R2 hold when disabled, R3 status lag, R4/R5 chained carry, R10 irq
    wr(4'd2, 32'd4);
    ticks(2);
    rd(4'd6, va, vb); chk("R2 disabled hold", va, 0);
    wr(4'd0, 32'd3);
    ticks(1);
    rd(4'd9, va, vb); chk("R3 status after 1 tick", va, 0);
    ticks(1);
    rd(4'd9, va, vb); chk("R3 status after 2 ticks", va, 3);
    ticks(3);
    rd(4'd6, va, vb); chk("R2 count0", va, 5);
    rd(4'd7, va, vb); chk("R5 count1 not yet", va, 0);
    rd(4'd5, va, vb); chk("R4 cause0 on hit", va, 1);
    chk("R10 masked irq", {31'b0, irq_a}, 0);
    ticks(1);
    rd(4'd7, va, vb); chk("R5 count1 one tick later", va, 1);
    rd(4'd6, va, vb); chk("R4 no clear keeps counting", va, 6);
    wr(4'd4, 32'd1);
    chk("R10 unmasked irq", {31'b0, irq_a}, 1);
    wr(4'd5, 32'd1);
    chk("R10 irq after w1c", {31'b0, irq_a}, 0);
    rd(4'd5, va, vb); chk("R10 cause after w1c", va, 0);
    wr(4'd0, 32'd0);
    ticks(3);
    rd(4'd6, va, vb); chk("R2 hold after disable", va, 6);

    // R7 match update delay
    do_reset();
    wr(4'd1, 32'h02B);
    wr(4'd0, 32'd1);
    ticks(1);
    wr(4'd2, 32'd1);
    ticks(1);
    rd(4'd6, va, vb); chk("R7 old match on first tick", va, 2);
    rd(4'd5, va, vb); chk("R7 no early hit", va, 0);
    wr(4'd2, 32'd3);
    ticks(2);
    rd(4'd6, va, vb); chk("R4 clear on hit", va, 0);
    rd(4'd5, va, vb); chk("R7 new match effective", va, 1);

    // R5 chaining off
    do_reset();
    wr(4'd1, 32'h003);
    wr(4'd0, 32'd2);
    ticks(5);
    rd(4'd7, va, vb); chk("R5 count1 free with chaining off", va, 5);

    // R6 sweep: both hit rules on the chained delay
    for (int m0 = 1; m0 <= 3; m0++) begin
      for (int m1 = 1; m1 <= 2; m1++) begin
        int tp, te;
        tp = (m1 + 1) * (m0 + 1) + 1;
        te = m1 * (m0 + 1) + 1;
        do_reset();
        wr(4'd1, 32'h02A);
        wr(4'd2, m0);
        wr(4'd3, m1);
        ticks(2);
        wr(4'd0, 32'd3);
        for (int t = 1; t <= tp; t++) begin
          ticks(1);
          rd(4'd5, va, vb);
          chk("R6 past-rule cause1", {31'b0, va[1]}, (t >= tp) ? 1 : 0);
          chk("R6 equality-rule cause1", {31'b0, vb[1]}, (t >= te) ? 1 : 0);
        end
      end
    end

    // R8 toggle bit sweep
    for (int tg = 0; tg <= 2; tg++) begin
      int tf;
      tf = 1 << tg;
      do_reset();
      wr(4'd1, 32'h004 | (tg << 7));
      wr(4'd0, 32'd4);
      for (int t = 1; t <= tf + 1; t++) begin
        ticks(1);
        rd(4'd5, va, vb);
        chk("R8 toggle cause2", {31'b0, va[2]}, (t >= tf) ? 1 : 0);
      end
      rd(4'd8, va, vb); chk("R8 count2", va, tf + 1);
    end

    // R8 wrap
    do_reset();
    wr(4'd0, 32'd4);
    ticks((1 << C2W) - 1);
    rd(4'd8, va, vb); chk("R8 count2 at max", va, (1 << C2W) - 1);
    ticks(1);
    rd(4'd8, va, vb); chk("R8 count2 wraps", va, 0);

    // R9 C1 hits drive C2
    do_reset();
    wr(4'd1, 32'h078);
    wr(4'd2, 32'd1);
    wr(4'd3, 32'd0);
    ticks(2);
    wr(4'd0, 32'd7);
    ticks(7);
    rd(4'd8, va, vb); chk("R9 count2 after 7 ticks", va, 3);
    ticks(1);
    rd(4'd8, va, vb); chk("R9 count2 holds between hits", va, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule